// File: doc/BRIEF.md
# E3 Receive Frame Alignment Tracker

This block sits behind the line interface of an E3 receiver and turns a plain serial bit stream into a frame position. Bits arrive on `bit_in`, qualified by the enable `bit_en`. While unlocked, the block compares the last ten bits against the alignment word at every bit. A candidate position is then confirmed by checking the same ten-bit slot exactly one frame later. Once locked, the block looks only at the expected slot, once per frame. It drops to an out-of-frame condition after repeated misses.

While out of frame, `frame_pos` keeps counting on the last good timing, so downstream overhead and payload logic keeps a usable position. At the same time, a second counter hunts for a fresh alignment. If no new alignment is confirmed within a programmable number of frames, the block also raises loss-of-frame. A small clear-on-read status byte records the changes of condition for an interrupt path.

Top module: `e3_frame_align`

## Requirements
- R1: After reset, `in_frame`, `oof` and `lof` are 0, `irq_status` is 8'h00, `frame_pos` is 0, and the block searches for the alignment word.
- R2: The alignment word is 1111010000, with the leftmost bit received first. When the search finds it, the candidate is confirmed if the word appears again exactly FRAME_BITS bits later (default 1536). `in_frame` then rises, and `frame_pos` reads FAW_LEN-1 (9) on the last word bit.
- R3: If the confirming slot does not hold the word, the candidate is dropped, `in_frame` stays 0 and the search restarts.
- R4: While locked, `frame_pos` advances by one on each enabled bit and wraps from FRAME_BITS-1 to 0.
- R5: While locked, four consecutive frames with a wrong word in the expected slot raise `oof` and drop `in_frame`. Any correct word resets the miss count.
- R6: While `oof` is high, `frame_pos` keeps counting on the previous alignment.
- R7: While out of frame (with or without `lof`), a word found at any bit starts a hunt candidate. If the word appears again one frame later, `in_frame` returns, `oof` and `lof` fall, and `frame_pos` is re-aligned to the new position.
- R8: When `lof_long` is 0, `lof` rises at the 8th old-timing word slot after `oof` rose, unless lock was regained first. When `lof_long` is 1, this happens at the 24th slot. `oof` stays high while `lof` is high.
- R9: `irq_status` bit 3 is set whenever `oof` rises or falls. Bit 2 is set whenever `lof` rises or falls. Bit 4 is set when a regained lock lands on a different position than the old timing. Bits 7:5 and 1:0 always read 0.
- R10: A cycle with `stat_rd` high clears `irq_status`. A bit that is set in that same cycle stays set.
- R11: A cycle with `bit_en` low changes neither `frame_pos` nor the alignment state, whatever `bit_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Received serial data bit |
| lof_long | input | 1 | Selects the long (1) or short (0) loss-of-frame timeout |
| stat_rd | input | 1 | Read strobe; clears `irq_status` |
| frame_pos | output | $clog2(FRAME_BITS) | Bit position within the frame |
| in_frame | output | 1 | Alignment locked |
| oof | output | 1 | Out-of-frame condition |
| lof | output | 1 | Loss-of-frame condition |
| irq_status | output | 8 | Clear-on-read change-of-condition flags |

## Verification
The properties assume that `rst_n` is low at time zero and for at least one clock edge. They also assume that `stat_rd` is a single-cycle strobe, and that `bit_in` carries a meaningful value only when `bit_en` is high. The bench builds whole frames in which the payload is all zeros, so no payload bit can mimic the alignment word except where a case places a deliberate false or shifted copy. It pulses `stat_rd` for exactly one cycle, and in one run it leaves idle cycles with `bit_in` forced high between enabled bits.

// File: rtl/e3fa_pkg.sv
// Package: shared state encoding and status bit positions for the E3 frame
// alignment tracker. Assumes an 8-bit status byte.
package e3fa_pkg;
    typedef enum logic [2:0] {
        ST_SEARCH = 3'd0,
        ST_VERIFY = 3'd1,
        ST_LOCKED = 3'd2,
        ST_OOF    = 3'd3,
        ST_LOF    = 3'd4
    } fa_state_t;

    localparam int STAT_W    = 8;
    localparam int STAT_COFA = 4;
    localparam int STAT_OOF  = 3;
    localparam int STAT_LOF  = 2;
endpackage

// File: rtl/e3fa_word_detect.sv
// Module: sliding window over the received bits that flags the alignment
// word ending on the current enabled bit. Assumes the first received bit of
// the word is its most significant bit.
module e3fa_word_detect #(
    parameter int                 W       = 10,
    parameter logic [W-1:0]       PATTERN = 10'b1111010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic hit
);
    logic [W-1:0] win_q;
    logic [W-1:0] win_d;

    // Purpose: form the window as it will look with the new bit included.
    always_comb begin
        win_d = {win_q[W-2:0], bit_in};
        hit   = bit_en && (win_d == PATTERN);
    end

    // Purpose: shift the window only on enabled bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '0;
        else if (bit_en)
            win_q <= win_d;
    end
endmodule

// File: rtl/e3fa_pos_ctr.sv
// Module: modulo frame-position counter with a synchronous load. A load
// places the current bit at LOAD_VAL. Assumes load is asserted only together
// with adv.
module e3fa_pos_ctr #(
    parameter int  MOD      = 1536,
    parameter int  LOAD_VAL = 9,
    localparam int PW       = $clog2(MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    output logic [PW-1:0] pos
);
    localparam logic [PW-1:0] LAST = PW'(MOD - 1);
    localparam logic [PW-1:0] LVAL = PW'(LOAD_VAL);

    // Purpose: count enabled bits with wrap; a load re-bases the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (load)
            pos <= LVAL;
        else if (adv)
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/e3fa_status.sv
// Module: sticky change-of-condition flags with a clear-on-read strobe. A
// flag set in the same cycle as a read survives the read.
module e3fa_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         rd,
    output logic [W-1:0] flags
);
    // Purpose: clear on read, then merge new events so none is lost.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (rd ? '0 : flags) | set_vec;
    end
endmodule

// File: rtl/e3_frame_align.sv
// Module: E3 receive frame alignment tracker. It searches for the alignment
// word, confirms it one frame later, then tracks it. After repeated misses it
// flags out-of-frame, flywheels on the old timing while a second counter
// hunts, and escalates to loss-of-frame on a frame-count timeout.
// Assumes one received bit per cycle with bit_en high, at most.
module e3_frame_align #(
    parameter int                   FRAME_BITS = 1536,
    parameter int                   FAW_LEN    = 10,
    parameter logic [FAW_LEN-1:0]   FAW        = 10'b1111010000,
    parameter int                   MISS_LIMIT = 4,
    parameter int                   LOF_SHORT  = 8,
    parameter int                   LOF_LONG   = 24,
    localparam int                  PW         = $clog2(FRAME_BITS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_en,
    input  logic                       bit_in,
    input  logic                       lof_long,
    input  logic                       stat_rd,
    output logic [PW-1:0]              frame_pos,
    output logic                       in_frame,
    output logic                       oof,
    output logic                       lof,
    output logic [e3fa_pkg::STAT_W-1:0] irq_status
);
    import e3fa_pkg::*;

    localparam int            MW        = $clog2(MISS_LIMIT + 1);
    localparam int            TW        = $clog2(LOF_LONG + 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);
    localparam logic [PW-1:0] MARK_PRE  = PW'(FAW_LEN - 2);

    fa_state_t       state_q, state_d;
    logic [MW-1:0]   miss_q;
    logic [TW-1:0]   tmo_q;
    logic [TW-1:0]   tmo_last;
    logic            armed_q;
    logic            hit;
    logic [PW-1:0]   main_pos, hunt_pos;
    logic            main_mark, hunt_mark;
    logic            hunting, hunt_start, hunt_drop, reacq, main_load;
    logic            oof_edge, lof_edge, cofa;
    logic [STAT_W-1:0] st_set;

    e3fa_word_detect #(.W(FAW_LEN), .PATTERN(FAW)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .hit    (hit)
    );

    e3fa_pos_ctr #(.MOD(FRAME_BITS), .LOAD_VAL(FAW_LEN - 1)) u_main_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bit_en),
        .load  (main_load),
        .pos   (main_pos)
    );

    e3fa_pos_ctr #(.MOD(FRAME_BITS), .LOAD_VAL(FAW_LEN - 1)) u_hunt_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bit_en),
        .load  (hunt_start),
        .pos   (hunt_pos)
    );

    // Purpose: decode slot marks and hunt events from the counters and detector.
    always_comb begin
        main_mark  = bit_en && (main_pos == MARK_PRE);
        hunt_mark  = bit_en && (hunt_pos == MARK_PRE);
        hunting    = (state_q == ST_OOF) || (state_q == ST_LOF);
        hunt_start = hunting && !armed_q && hit;
        reacq      = hunting && armed_q && hunt_mark && hit;
        hunt_drop  = hunting && armed_q && hunt_mark && !hit;
        main_load  = ((state_q == ST_SEARCH) && hit) || reacq;
        tmo_last   = (lof_long ? TW'(LOF_LONG) : TW'(LOF_SHORT)) - 1'b1;
    end

    // Purpose: next-state decision of the alignment machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH: if (hit) state_d = ST_VERIFY;
            ST_VERIFY: if (main_mark) state_d = hit ? ST_LOCKED : ST_SEARCH;
            ST_LOCKED: if (main_mark && !hit && (miss_q == MISS_LAST))
                           state_d = ST_OOF;
            ST_OOF: begin
                if (reacq)
                    state_d = ST_LOCKED;
                else if (main_mark && (tmo_q == tmo_last))
                    state_d = ST_LOF;
            end
            ST_LOF:    if (reacq) state_d = ST_LOCKED;
            default:   state_d = ST_SEARCH;
        endcase
    end

    // Purpose: hold the alignment state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SEARCH;
        else
            state_q <= state_d;
    end

    // Purpose: count consecutive wrong words while locked.
    always_ff @(posedge clk) begin
        if (!rst_n || (state_q != ST_LOCKED))
            miss_q <= '0;
        else if (main_mark)
            miss_q <= hit ? '0 : miss_q + 1'b1;
    end

    // Purpose: count old-timing word slots spent out of frame before escalation.
    always_ff @(posedge clk) begin
        if (!rst_n || (state_q != ST_OOF))
            tmo_q <= '0;
        else if (main_mark)
            tmo_q <= tmo_q + 1'b1;
    end

    // Purpose: track whether a hunt candidate awaits its one-frame confirmation.
    always_ff @(posedge clk) begin
        if (!rst_n || !hunting)
            armed_q <= 1'b0;
        else if (hunt_start)
            armed_q <= 1'b1;
        else if (hunt_drop || reacq)
            armed_q <= 1'b0;
    end

    // Purpose: derive change-of-condition events for the status flags.
    always_comb begin
        oof_edge = ((state_q == ST_LOCKED) && (state_d == ST_OOF))
                || (hunting && (state_d == ST_LOCKED));
        lof_edge = (state_q == ST_LOF) != (state_d == ST_LOF);
        cofa     = reacq && !main_mark;
        st_set            = '0;
        st_set[STAT_OOF]  = oof_edge;
        st_set[STAT_LOF]  = lof_edge;
        st_set[STAT_COFA] = cofa;
    end

    e3fa_status #(.W(STAT_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (st_set),
        .rd      (stat_rd),
        .flags   (irq_status)
    );

    // Purpose: drive the condition outputs from the state register.
    always_comb begin
        frame_pos = main_pos;
        in_frame  = (state_q == ST_LOCKED);
        oof       = (state_q == ST_OOF) || (state_q == ST_LOF);
        lof       = (state_q == ST_LOF);
    end
endmodule

// File: rtl/e3fa_checker.sv
// Module: temporal properties of the frame alignment tracker, observed at its
// ports and bound to every instance of the top module.
module e3fa_checker #(
    parameter int  FRAME_BITS = 1536,
    parameter int  FAW_LEN    = 10,
    localparam int PW         = $clog2(FRAME_BITS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic [PW-1:0] frame_pos,
    input logic          in_frame,
    input logic          oof,
    input logic          lof,
    input logic [7:0]    irq_status
);
    logic [PW-1:0] pos_inc;

    // Purpose: expected position after one more enabled bit.
    always_comb
        pos_inc = (frame_pos == PW'(FRAME_BITS - 1)) ? '0 : frame_pos + 1'b1;

    assert_lock_on_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> (frame_pos == PW'(FAW_LEN - 1)));

    assert_pos_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && $past(in_frame) && $past(bit_en)) |-> (frame_pos == $past(pos_inc)));

    assert_oof_from_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oof) |-> $past(in_frame));

    assert_oof_exit_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oof) |-> (in_frame && !lof));

    assert_lof_from_oof_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof) |-> $past(oof));

    assert_oof_rise_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oof) |-> irq_status[3]);

    assert_oof_fall_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oof) |-> irq_status[3]);

    assert_lof_rise_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof) |-> irq_status[2]);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_en)) |-> ($stable(frame_pos) && $stable(in_frame) && $stable(oof)));
endmodule

bind e3_frame_align e3fa_checker #(.FRAME_BITS(FRAME_BITS), .FAW_LEN(FAW_LEN)) i_e3fa_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .frame_pos  (frame_pos),
    .in_frame   (in_frame),
    .oof        (oof),
    .lof        (lof),
    .irq_status (irq_status)
);

// File: tb/test_e3_frame_align.sv
// Bench: table of whole-frame scenarios followed by directed cases, using a
// short frame so timeouts fit in a brief run.
module test_e3_frame_align;
    localparam int   CLK_PERIOD = 10;
    localparam int   FB         = 64;
    localparam int   PW         = $clog2(FB);
    localparam logic [9:0] WORD = 10'b1111010000;
    localparam int   SHIFT_OFS  = 20;
    localparam int   WATCHDOG   = 150000;

    // Row: kind[19:18] (0 bad, 1 good, 2 shifted) | exp {in,oof,lof}[17:15]
    //      | read[14] | exp status[13:6] | exp pos[5:0]
    localparam int NV = 32;
    localparam logic [19:0] VEC [NV] = '{
        {2'd1, 3'b000, 1'b0, 8'h00, 6'd63},
        {2'd1, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd1, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd1, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd1, 3'b100, 1'b1, 8'h08, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd0, 3'b011, 1'b0, 8'h00, 6'd63},
        {2'd1, 3'b011, 1'b0, 8'h00, 6'd63},
        {2'd1, 3'b100, 1'b1, 8'h0C, 6'd63},
        {2'd2, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd2, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd2, 3'b100, 1'b0, 8'h00, 6'd63},
        {2'd2, 3'b010, 1'b0, 8'h00, 6'd63},
        {2'd2, 3'b100, 1'b1, 8'h18, 6'd43},
        {2'd2, 3'b100, 1'b0, 8'h00, 6'd43}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          bit_in = 1'b0;
    logic          lof_long = 1'b0;
    logic          stat_rd = 1'b0;
    logic [PW-1:0] frame_pos;
    logic          in_frame, oof, lof;
    logic [7:0]    irq_status;
    logic          gaps = 1'b0;
    int            n_chk = 0;
    int            n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    e3_frame_align #(.FRAME_BITS(FB)) i_e3_frame_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .lof_long   (lof_long),
        .stat_rd    (stat_rd),
        .frame_pos  (frame_pos),
        .in_frame   (in_frame),
        .oof        (oof),
        .lof        (lof),
        .irq_status (irq_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic rd);
        bit_in  = b;
        bit_en  = 1'b1;
        stat_rd = rd;
        @(negedge clk);
        bit_en  = 1'b0;
        stat_rd = 1'b0;
        if (gaps) begin
            bit_in = 1'b1;
            @(negedge clk);
        end
    endtask

    // kind 0: no word, 1: word at bit 0, 2: word at SHIFT_OFS; rd_at pulses a read
    task automatic send_frame(input int kind, input int rd_at);
        for (int b = 0; b < FB; b++) begin
            logic v;
            v = 1'b0;
            if (kind == 1 && b < 10) v = WORD[9 - b];
            if (kind == 2 && b >= SHIFT_OFS && b < SHIFT_OFS + 10) v = WORD[9 - (b - SHIFT_OFS)];
            send_bit(v, b == rd_at);
        end
    endtask

    task automatic pulse_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bit_en = 1'b0;
        stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [PW-1:0] held;
        do_reset();
        // R1: reset state
        check("R1 flags", {in_frame, oof, lof}, 3'b000);
        check("R1 status", irq_status, 8'h00);
        check("R1 pos", frame_pos, 0);

        // Scenario table: R2 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            send_frame(int'(VEC[i][19:18]), -1);
            check($sformatf("R5/R7/R8 row %0d state", i), {in_frame, oof, lof}, VEC[i][17:15]);
            check($sformatf("R4/R6 row %0d pos", i), frame_pos, VEC[i][5:0]);
            if (VEC[i][14]) begin
                check($sformatf("R9 row %0d status", i), irq_status, VEC[i][13:6]);
                pulse_read();
                check($sformatf("R10 row %0d cleared", i), irq_status, 8'h00);
            end
        end

        // R3: a false candidate is rejected
        do_reset();
        send_frame(1, -1);
        send_frame(0, -1);
        check("R3 false candidate", {in_frame, oof, lof}, 3'b000);
        send_frame(1, -1);
        send_frame(1, -1);
        check("R2 lock after reject", {in_frame, oof, lof}, 3'b100);

        // R8: long timeout, 24 slots
        lof_long = 1'b1;
        for (int k = 0; k < 4; k++) send_frame(0, -1);
        check("R5 oof before long timeout", {in_frame, oof, lof}, 3'b010);
        for (int k = 0; k < 23; k++) send_frame(0, -1);
        check("R8 no lof at 23", {in_frame, oof, lof}, 3'b010);
        send_frame(0, -1);
        check("R8 lof at 24", {in_frame, oof, lof}, 3'b011);
        send_frame(1, -1);
        send_frame(1, -1);
        check("R7 relock from lof", {in_frame, oof, lof}, 3'b100);
        check("R9 oof+lof flags", irq_status, 8'h0C);

        // R10: set and read in the same cycle keeps the flag
        pulse_read();
        for (int k = 0; k < 3; k++) send_frame(0, -1);
        send_frame(0, 9);
        check("R10 set wins over read", irq_status, 8'h08);
        check("R5 oof entered", oof, 1'b1);

        // R1: reset mid-run clears everything
        do_reset();
        check("R1 reset oof", {in_frame, oof, lof}, 3'b000);
        check("R1 reset status", irq_status, 8'h00);

        // R11: idle cycles with bit_in high change nothing
        gaps = 1'b1;
        send_frame(1, -1);
        held = frame_pos;
        bit_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 pos held", frame_pos, held);
        send_frame(1, -1);
        check("R11 lock through gaps", {in_frame, oof, lof}, 3'b100);
        check("R11 pos with gaps", frame_pos, FB - 1);
        gaps = 1'b0;

        summary();
    end
endmodule